// File: doc/BRIEF.md
# Serial Burst Write Receiver

This block sits behind a debug shift register and accepts a serial burst-write transaction one bit at a time. Each accepted bit is qualified by `bitValid`. A 53-bit command comes in first and sets the word size, the start address and the number of words. After the command the receiver waits for a start marker, which is the first 1 bit. It then packs the payload into words and hands each word to a simple request/acknowledge write port with an incrementing address.

While the payload streams in, a bit-serial reflected CRC runs over it. The host then sends its own 32-bit checksum. The receiver answers with one match bit, which is valid on `matchValid`. The next qualified bit consumes that answer, and the receiver is then ready for a new command. A failed bus write is recorded with its address. The rest of the burst is still written, so the host can decide afterwards whether to retry.

Top module: `burst_write_rx`

## Requirements
- R1: After reset, `wrReq`, `matchValid` and `errFlag` are low.
- R2: A command is 53 qualified bits, least significant bit first. Bit 52 must be 0. Bits 51:48 give the opcode: 1 selects 8-bit words, 2 selects 16-bit words and 3 selects 32-bit words. Bits 47:16 give the start address and bits 15:0 give the word count. A command with bit 52 set, any other opcode, a count of 0 or a count above MAX_WORDS (4096) is dropped. A dropped command causes no write and no match report, and the next 53 bits are taken as a new command.
- R3: After an accepted command, 0 bits are discarded until the first 1 bit arrives. That 1 bit is the start marker and is not part of the payload.
- R4: Payload bits fill each word least significant bit first. Each word appears right-aligned on `wrData`, with all upper bits zero. `wrSize` is 0 for 8-bit words, 1 for 16-bit words and 2 for 32-bit words.
- R5: The first word goes to the start address. Each later word's address is higher by the word size in bytes (1, 2 or 4). Exactly the commanded number of writes is issued.
- R6: `wrReq` stays high, with `wrAddr` and `wrData` unchanged, until the cycle in which `wrAck` is high.
- R7: The checksum starts at all ones and covers only payload bits. For each bit, the feedback is the data bit XOR checksum bit 0. The checksum shifts right by one and is XORed with 0xEDB88320 when the feedback is 1. No final inversion is applied.
- R8: The received checksum is 32 bits, least significant bit first. In the cycle after its last bit, `matchValid` rises. `matchBit` is 1 if the received checksum equals the computed one and 0 otherwise. The next qualified bit clears `matchValid`.
- R9: When `wrErr` is high together with `wrAck`, `errFlag` is set and `errAddr` takes that write's address. The remaining words of the burst are still written. Accepting the next valid command clears `errFlag`.
- R10: Bits presented while `bitValid` is low have no effect, including a 1 on `bitIn` while the receiver waits for the start marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Serial command, payload and checksum bit |
| matchValid | output | 1 | Checksum verdict is being presented |
| matchBit | output | 1 | 1 when the checksums agree |
| wrReq | output | 1 | Write request, held until acknowledged |
| wrAddr | output | 32 | Byte address of the write |
| wrData | output | 32 | Right-aligned write data |
| wrSize | output | 2 | Word size code (0/1/2 = 8/16/32 bits) |
| wrAck | input | 1 | Write accepted this cycle |
| wrErr | input | 1 | The acknowledged write failed |
| errFlag | output | 1 | A write of the current burst failed |
| errAddr | output | 32 | Address of the most recent failed write |

## Verification
The assertions assume that the write port acknowledges each word before the next word finishes arriving, since the receiver holds only one pending word. The bench responder therefore acknowledges one cycle after it sees a request, which is far less than the 8 qualified bits of the shortest word. The assertions also assume that `wrErr` is meaningful only together with `wrAck`, and the responder raises it only in an acknowledge cycle. Idle gaps in `bitValid` lengthen the time per word, so they can only widen that margin.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

  localparam int CMD_LEN = 53;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int LEN_W   = 16;
  localparam int OPC_W   = 4;
  localparam int CRC_W   = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_SEEK,
    ST_DATA,
    ST_CHK,
    ST_REPORT
  } rxState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic cmdShift;
    logic cmdTake;
    logic dataBit;
    logic wordDone;
    logic chkBit;
  } rxStrobe_t;

endpackage

// File: rtl/bwr_ctrl.sv
module bwr_ctrl
  import bwr_pkg::*;
#(
  parameter int MAX_WORDS = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             bitIn,
  input  logic             cmdMark,
  input  logic [OPC_W-1:0] cmdOpc,
  input  logic [LEN_W-1:0] cmdLen,
  output rxStrobe_t        stb,
  output logic [1:0]       sizeCode,
  output logic             matchValid
);

  localparam int CNT_W = $clog2(CMD_LEN);
  localparam int WL_W  = $clog2(MAX_WORDS + 1);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_WORDS);

  rxState_e         state;
  logic [CNT_W-1:0] cmdCnt;
  logic [4:0]       bitCnt;
  logic [4:0]       chkCnt;
  logic [WL_W-1:0]  wordsLeft;
  logic [4:0]       wordBitsM1;
  logic             cmdOk;
  logic             cmdLast;

  assign cmdOk = !cmdMark && (cmdOpc inside {4'd1, 4'd2, 4'd3}) &&
                 (cmdLen != '0) && (cmdLen <= MAX_LEN);
  assign cmdLast = (cmdCnt == CNT_W'(CMD_LEN - 1));

  always_comb begin
    case (sizeCode)
      2'd0:    wordBitsM1 = 5'd7;
      2'd1:    wordBitsM1 = 5'd15;
      default: wordBitsM1 = 5'd31;
    endcase
  end

  always_comb begin
    stb = '0;
    case (state)
      ST_CMD: begin
        stb.cmdShift = bitValid;
        stb.cmdTake  = bitValid && cmdLast && cmdOk;
      end
      ST_DATA: begin
        stb.dataBit  = bitValid;
        stb.wordDone = bitValid && (bitCnt == wordBitsM1);
      end
      ST_CHK:  stb.chkBit = bitValid;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_CMD;
      cmdCnt    <= '0;
      bitCnt    <= '0;
      chkCnt    <= '0;
      wordsLeft <= '0;
      sizeCode  <= 2'd2;
    end else if (bitValid) begin
      case (state)
        ST_CMD: begin
          if (cmdLast) begin
            cmdCnt <= '0;
            if (cmdOk) begin
              state     <= ST_SEEK;
              wordsLeft <= cmdLen[WL_W-1:0];
              sizeCode  <= cmdOpc[1:0] - 2'd1;
            end
          end else begin
            cmdCnt <= cmdCnt + 1'b1;
          end
        end
        ST_SEEK: begin
          if (bitIn) begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end
        end
        ST_DATA: begin
          if (bitCnt == wordBitsM1) begin
            bitCnt    <= '0;
            wordsLeft <= wordsLeft - 1'b1;
            if (wordsLeft == WL_W'(1)) begin
              state  <= ST_CHK;
              chkCnt <= '0;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_CHK: begin
          if (chkCnt == 5'd31) state <= ST_REPORT;
          else                 chkCnt <= chkCnt + 1'b1;
        end
        ST_REPORT: begin
          state  <= ST_CMD;
          cmdCnt <= '0;
        end
        default: state <= ST_CMD;
      endcase
    end
  end

  assign matchValid = (state == ST_REPORT);

  // R3
  seek_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEEK && (!bitValid || !bitIn)) |=> state == ST_SEEK);

  // R5
  words_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHK || state == ST_REPORT) |-> wordsLeft == '0);

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> $stable(state));

endmodule

// File: rtl/bwr_datapath.sv
module bwr_datapath
  import bwr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  rxStrobe_t         stb,
  input  logic [1:0]        sizeCode,
  input  logic              wrAck,
  input  logic              wrErr,
  output logic              cmdMark,
  output logic [OPC_W-1:0]  cmdOpc,
  output logic [LEN_W-1:0]  cmdLen,
  output logic              crcMatch,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              errFlag,
  output logic [ADDR_W-1:0] errAddr
);

  logic [CMD_LEN-2:0] cmdSr;
  logic [CMD_LEN-1:0] cmdNext;
  logic [DATA_W-2:0]  wordSr;
  logic [DATA_W-1:0]  wordNext;
  logic [DATA_W-1:0]  aligned;
  logic [CRC_W-1:0]   crcCalc;
  logic [CRC_W-1:0]   crcStep;
  logic [CRC_W-1:0]   crcRx;
  logic [ADDR_W-1:0]  addrNext;
  logic [ADDR_W-1:0]  addrStep;
  logic               feedback;

  assign cmdNext = {bitIn, cmdSr};
  assign cmdMark = cmdNext[52];
  assign cmdOpc  = cmdNext[51:48];
  assign cmdLen  = cmdNext[15:0];

  assign wordNext = {bitIn, wordSr};

  always_comb begin
    case (sizeCode)
      2'd0: begin
        aligned  = {24'b0, wordNext[31:24]};
        addrStep = ADDR_W'(1);
      end
      2'd1: begin
        aligned  = {16'b0, wordNext[31:16]};
        addrStep = ADDR_W'(2);
      end
      default: begin
        aligned  = wordNext;
        addrStep = ADDR_W'(4);
      end
    endcase
  end

  assign feedback = bitIn ^ crcCalc[0];
  assign crcStep  = {1'b0, crcCalc[CRC_W-1:1]} ^ (feedback ? CRC_POLY : '0);
  assign crcMatch = (crcRx == crcCalc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSr    <= '0;
      wordSr   <= '0;
      crcCalc  <= '1;
      crcRx    <= '0;
      addrNext <= '0;
      wrReq    <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      errFlag  <= 1'b0;
      errAddr  <= '0;
    end else begin
      if (stb.cmdShift) cmdSr <= cmdNext[CMD_LEN-1:1];
      if (stb.cmdTake) begin
        addrNext <= cmdNext[47:16];
        crcCalc  <= '1;
        errFlag  <= 1'b0;
      end
      if (stb.dataBit) begin
        wordSr  <= wordNext[DATA_W-1:1];
        crcCalc <= crcStep;
      end
      if (stb.chkBit) crcRx <= {bitIn, crcRx[CRC_W-1:1]};
      if (wrReq && wrAck && wrErr) begin
        errFlag <= 1'b1;
        errAddr <= wrAddr;
      end
      if (stb.wordDone) begin
        wrReq    <= 1'b1;
        wrAddr   <= addrNext;
        wrData   <= aligned;
        addrNext <= addrNext + addrStep;
      end else if (wrReq && wrAck) begin
        wrReq <= 1'b0;
      end
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck) |=> (wrReq && $stable(wrAddr) && $stable(wrData)));

  // R6
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wordDone |-> !(wrReq && !wrAck));

  // R9
  err_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrAck && wrErr && !stb.cmdTake) |=> (errFlag && errAddr == $past(wrAddr)));

  // R4
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && sizeCode == 2'd0) |-> wrData[31:8] == '0);

endmodule

// File: rtl/burst_write_rx.sv
module burst_write_rx
  import bwr_pkg::*;
#(
  parameter int MAX_WORDS = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitValid,
  input  logic        bitIn,
  output logic        matchValid,
  output logic        matchBit,
  output logic        wrReq,
  output logic [31:0] wrAddr,
  output logic [31:0] wrData,
  output logic [1:0]  wrSize,
  input  logic        wrAck,
  input  logic        wrErr,
  output logic        errFlag,
  output logic [31:0] errAddr
);

  rxStrobe_t        stb;
  logic             cmdMark;
  logic [OPC_W-1:0] cmdOpc;
  logic [LEN_W-1:0] cmdLen;
  logic [1:0]       sizeCode;
  logic             crcMatch;

  bwr_ctrl #(.MAX_WORDS(MAX_WORDS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .bitValid   (bitValid),
    .bitIn      (bitIn),
    .cmdMark    (cmdMark),
    .cmdOpc     (cmdOpc),
    .cmdLen     (cmdLen),
    .stb        (stb),
    .sizeCode   (sizeCode),
    .matchValid (matchValid)
  );

  bwr_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .bitIn    (bitIn),
    .stb      (stb),
    .sizeCode (sizeCode),
    .wrAck    (wrAck),
    .wrErr    (wrErr),
    .cmdMark  (cmdMark),
    .cmdOpc   (cmdOpc),
    .cmdLen   (cmdLen),
    .crcMatch (crcMatch),
    .wrReq    (wrReq),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .errFlag  (errFlag),
    .errAddr  (errAddr)
  );

  assign wrSize   = sizeCode;
  assign matchBit = matchValid & crcMatch;

  // R8
  verdict_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && bitValid) |=> !matchValid);

endmodule

// File: tb/burst_write_rx_tb_top.sv
`timescale 1ns/1ps
module burst_write_rx_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        bitValid;
  logic        bitIn;
  logic        matchValid;
  logic        matchBit;
  logic        wrReq;
  logic [31:0] wrAddr;
  logic [31:0] wrData;
  logic [1:0]  wrSize;
  logic        wrAck;
  logic        wrErr;
  logic        errFlag;
  logic [31:0] errAddr;

  always #2 clk = ~clk;

  burst_write_rx dut_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .matchValid(matchValid), .matchBit(matchBit),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrSize(wrSize),
    .wrAck(wrAck), .wrErr(wrErr), .errFlag(errFlag), .errAddr(errAddr)
  );

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] qAddr[$];
  logic [31:0] qData[$];
  int          qSize[$];

  bit          expMV = 1'b0;
  bit          expMB = 1'b0;
  bit          errInjOn = 1'b0;
  logic [31:0] errInjAddr = '0;
  int          waitCnt = 0;
  logic [31:0] seenA, seenD;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // verdict model compared on every clock (R8)
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      check(matchValid == expMV, "R8", "matchValid", 32'(matchValid), 32'(expMV));
      if (expMV) check(matchBit == expMB, "R7", "matchBit", 32'(matchBit), 32'(expMB));
    end
  end

  // write port responder
  initial begin
    wrAck = 1'b0;
    wrErr = 1'b0;
    forever begin
      @(negedge clk);
      if (wrAck) begin
        wrAck = 1'b0;
        wrErr = 1'b0;
        waitCnt = 0;
      end else if (wrReq) begin
        if (waitCnt == 0) begin
          seenA = wrAddr;
          seenD = wrData;
          waitCnt = 1;
        end else begin
          check(wrAddr == seenA && wrData == seenD, "R6", "held request", wrAddr, seenA);
          if (qAddr.size() == 0) begin
            check(1'b0, "R2", "unexpected write", wrAddr, 32'hFFFF_FFFF);
          end else begin
            check(wrAddr == qAddr[0], "R5", "write address", wrAddr, qAddr[0]);
            check(wrData == qData[0], "R4", "write data", wrData, qData[0]);
            check(32'(wrSize) == qSize[0], "R4", "write size", 32'(wrSize), qSize[0]);
            void'(qAddr.pop_front());
            void'(qData.pop_front());
            void'(qSize.pop_front());
          end
          wrAck = 1'b1;
          wrErr = errInjOn && (wrAddr == errInjAddr);
        end
      end
    end
  end

  task automatic sendBit(input bit b);
    @(negedge clk);
    bitValid = 1'b1;
    bitIn    = b;
  endtask

  // idle cycles with bitIn high: must be ignored (R10)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitValid = 1'b0;
      bitIn    = 1'b1;
    end
  endtask

  task automatic sendCmd(input logic [52:0] c);
    for (int i = 0; i < 53; i++) sendBit(c[i]);
  endtask

  task automatic burst(input int op, input logic [31:0] addr, input int len,
                       input int zeros, input bit badCrc, input int gapEvery);
    int bits = 8 << (op - 1);
    int bytesPer = 1 << (op - 1);
    logic [31:0] crc = 32'hFFFF_FFFF;
    logic [52:0] c = {1'b0, op[3:0], addr, len[15:0]};
    sendCmd(c);
    for (int z = 0; z < zeros; z++) sendBit(1'b0);
    if (gapEvery != 0) idle(3);
    sendBit(1'b1);
    for (int w = 0; w < len; w++) begin
      logic [31:0] word = 32'hA5C3_1E70 ^ (32'(w) * 32'h0101_0137);
      if (bits == 8)       word = word & 32'h0000_00FF;
      else if (bits == 16) word = word & 32'h0000_FFFF;
      qAddr.push_back(addr + 32'(w * bytesPer));
      qData.push_back(word);
      qSize.push_back(op - 1);
      for (int b = 0; b < bits; b++) begin
        bit x = word[b];
        bit fb = x ^ crc[0];
        crc = (crc >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
        sendBit(x);
        if (gapEvery != 0 && (b % gapEvery) == 0) idle(2);
      end
    end
    if (badCrc) crc = crc ^ 32'h0000_0010;
    for (int k = 0; k < 32; k++) sendBit(crc[k]);
    expMV = 1'b1;
    expMB = !badCrc;
    sendBit(1'b0);
    expMV = 1'b0;
    idle(6);
    check(qAddr.size() == 0, "R5", "all words written", 32'(qAddr.size()), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    bitValid = 1'b0;
    bitIn = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(wrReq == 1'b0, "R1", "wrReq after reset", 32'(wrReq), 0);
    check(matchValid == 1'b0, "R1", "matchValid after reset", 32'(matchValid), 0);
    check(errFlag == 1'b0, "R1", "errFlag after reset", 32'(errFlag), 0);

    // R3 R4 R5 R7: 32-bit words with leading zeros
    burst(3, 32'h0000_1000, 3, 5, 1'b0, 0);
    // R10 R4 R5: bytes at odd address with gaps
    burst(1, 32'h0000_2001, 5, 0, 1'b0, 3);
    // R8: halfwords with corrupted checksum
    burst(2, 32'h0000_3002, 4, 2, 1'b1, 0);

    // R2: dropped commands (bad opcode, marker set, zero length, too long)
    sendCmd({1'b0, 4'h5, 32'h0000_4000, 16'd2});
    sendCmd({1'b1, 4'h3, 32'h0000_4000, 16'd2});
    sendCmd({1'b0, 4'h3, 32'h0000_4000, 16'd0});
    sendCmd({1'b0, 4'h1, 32'h0000_4000, 16'd4097});
    idle(4);
    check(wrReq == 1'b0, "R2", "no write after dropped commands", 32'(wrReq), 0);
    // R2: a valid command right after still works
    burst(3, 32'h0000_5000, 2, 1, 1'b0, 0);

    // R9: bus error on the second word, remaining words still written
    errInjOn = 1'b1;
    errInjAddr = 32'h0000_6004;
    burst(3, 32'h0000_6000, 4, 0, 1'b0, 0);
    errInjOn = 1'b0;
    check(errFlag == 1'b1, "R9", "errFlag set", 32'(errFlag), 1);
    check(errAddr == 32'h0000_6004, "R9", "errAddr", errAddr, 32'h0000_6004);
    burst(1, 32'h0000_7000, 2, 0, 1'b0, 0);
    check(errFlag == 1'b0, "R9", "errFlag cleared by new command", 32'(errFlag), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule